// File: doc/BRIEF.md
# Memory-to-Memory Teaching Processor

This block is a small stored-program processor. Code and data share one byte-wide, 256-cell memory. The processor has no register file. Every operand is read from a memory cell, and every result is written back to a memory cell. Instructions are fixed four-byte words. A multi-cycle sequencer works through them: it reads the four instruction bytes, then reads each operand (following a pointer cell when a source asks for indirection), then writes the result and moves the program counter on.

The memory attached to the block is synchronous and single-ported. Read data appears one clock after the address is presented, and a write happens on the clock edge where the write enable is high. The block has two status outputs. The first reports that the sequencer has stopped on an operator code it does not recognise. The second is a sticky flag raised by division by zero. Both are cleared only by reset.

Top module: `mm_cpu`

## Requirements
- R1: While reset is asserted, the program counter is 0, mem_addr shows 0, mem_we is low and halted and div_err are low. The first fetch after reset reads address 0.
- R2: An instruction is four consecutive bytes starting at the program counter, in this order: operator, source A, source B, destination. The word 01 1C 3F 64 adds cell 28 to cell 63 and writes the sum to cell 100. After any instruction that does not branch, the program counter increases by 4.
- R3: Operator 1 adds, 2 subtracts, 3 multiplies and 4 divides. All four are unsigned, and results keep the low 8 bits. The destination byte is a full 8-bit address.
- R4: For operators 1 to 4, bit 7 of a source byte selects indirection. Bits 6:0 name a cell. When bit 7 is set, the byte held in that cell is used as the address of the real operand.
- R5: Division by zero writes 0xFF to the destination and sets div_err. div_err then stays high until reset, even after later valid instructions.
- R6: Operator 5 reads the cell whose full 8-bit address is in the source A byte and writes that value minus 1 back to the same cell. 0 becomes 255.
- R7: Operator 6 (branch if zero) and operator 7 (branch if non-zero) test the cell addressed by the source A byte. If the condition holds, the program counter is loaded with the destination byte. Otherwise it increases by 4.
- R8: Operator 8 loads the program counter with the destination byte unconditionally.
- R9: Operator 0, and any operator from 9 to 255, sets halted. The sequencer then stops: no further memory writes, mem_addr holds the address of the offending instruction, and halted stays high until reset.
- R10: Each arithmetic or decrement instruction writes memory in exactly one cycle. Branch and jump instructions make no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | 8 | Memory address for the current read or write |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable, active high |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| halted | output | 1 | Sequencer stopped on an undefined operator |
| div_err | output | 1 | Sticky division-by-zero flag |

## Verification
A wrong program counter shows up as a wrong fetch address within one instruction. It also changes which cells are written, or where the block halts, because every test program ends on an undefined operator and mem_addr then shows the final program counter. A corrupted operand or indirection state appears as a wrong byte in the destination cell at the end of that instruction's write cycle. The bench also counts write cycles, so a branch that writes, or an arithmetic instruction that writes twice, is seen by the end of the program. The sticky flags are checked after later instructions have run, so a flag that clears itself or never sets is seen when the program halts.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam logic [7:0] OPC_ADD = 8'd1;
  localparam logic [7:0] OPC_SUB = 8'd2;
  localparam logic [7:0] OPC_MUL = 8'd3;
  localparam logic [7:0] OPC_DIV = 8'd4;
  localparam logic [7:0] OPC_DEC = 8'd5;
  localparam logic [7:0] OPC_BZ  = 8'd6;
  localparam logic [7:0] OPC_BNZ = 8'd7;
  localparam logic [7:0] OPC_JMP = 8'd8;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_DEC
  } alu_op_e;

  typedef enum logic [3:0] {
    S_IFETCH, S_ICAP, S_DECODE, S_RDA, S_CAPA, S_RDB, S_CAPB, S_EXEC, S_HALT
  } seq_state_e;
endpackage

// File: rtl/mm_alu.sv
module mm_alu
  import mm_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y,
  output logic            div0
);
  localparam int PW = 2 * DW;
  logic [PW-1:0] prod;

  assign prod = a * b;
  assign div0 = (op == ALU_DIV) && (b == '0);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_MUL: y = prod[DW-1:0];
      ALU_DIV: y = (b == '0) ? '1 : (a / b);
      ALU_DEC: y = a - DW'(1);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output alu_op_e         alu_op,
  output logic [DW-1:0]   alu_a,
  output logic [DW-1:0]   alu_b,
  input  logic [DW-1:0]   alu_y,
  input  logic            alu_div0,
  output logic            halted,
  output logic            div_err
);
  localparam int NB = 4;
  localparam int IW = $clog2(NB);
  localparam logic [DW-1:0] STEP = DW'(NB);

  seq_state_e     state_q, state_d;
  logic [DW-1:0]  pc_q, pc_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [DW-1:0]  opa_q, opa_d, opb_q, opb_d;
  logic           deref_q, deref_d;
  logic           err_q, err_d;
  logic [DW-1:0]  ir_q [NB];

  logic [DW-1:0]  opc, src_a, src_b, dst;
  logic           is_arith, is_dec, is_br, ind_a, ind_b, br_take;
  logic [DW-1:0]  addr_a, addr_b, pc_seq;

  assign opc   = ir_q[0];
  assign src_a = ir_q[1];
  assign src_b = ir_q[2];
  assign dst   = ir_q[3];

  assign is_arith = (opc >= OPC_ADD) && (opc <= OPC_DIV);
  assign is_dec   = (opc == OPC_DEC);
  assign is_br    = (opc == OPC_BZ) || (opc == OPC_BNZ);
  assign ind_a    = is_arith && src_a[DW-1];
  assign ind_b    = src_b[DW-1];
  assign addr_a   = is_arith ? {1'b0, src_a[DW-2:0]} : src_a;
  assign addr_b   = {1'b0, src_b[DW-2:0]};
  assign pc_seq   = pc_q + STEP;
  assign br_take  = (opc == OPC_BZ) ? (mem_rdata == '0) : (mem_rdata != '0);

  // instruction byte registers, one enable per byte
  for (genvar g = 0; g < NB; g++) begin : g_ir
    logic ir_en;
    assign ir_en = (state_q == S_ICAP) && (idx_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ir_q[g] <= '0;
      end else if (ir_en) begin
        ir_q[g] <= mem_rdata;
      end
    end
  end

  always_comb begin
    case (opc)
      OPC_SUB: alu_op = ALU_SUB;
      OPC_MUL: alu_op = ALU_MUL;
      OPC_DIV: alu_op = ALU_DIV;
      OPC_DEC: alu_op = ALU_DEC;
      default: alu_op = ALU_ADD;
    endcase
  end

  assign alu_a = opa_q;
  assign alu_b = opb_q;

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    idx_d     = idx_q;
    opa_d     = opa_q;
    opb_d     = opb_q;
    deref_d   = deref_q;
    err_d     = err_q;
    mem_addr  = pc_q + DW'(idx_q);
    mem_wdata = alu_y;
    mem_we    = 1'b0;
    case (state_q)
      S_IFETCH: state_d = S_ICAP;
      S_ICAP: begin
        if (idx_q == IW'(NB - 1)) begin
          idx_d   = '0;
          state_d = S_DECODE;
        end else begin
          idx_d   = idx_q + IW'(1);
          state_d = S_IFETCH;
        end
      end
      S_DECODE: begin
        deref_d = 1'b0;
        if (is_arith || is_dec || is_br) begin
          state_d = S_RDA;
        end else if (opc == OPC_JMP) begin
          pc_d    = dst;
          state_d = S_IFETCH;
        end else begin
          state_d = S_HALT;
        end
      end
      S_RDA: begin
        mem_addr = deref_q ? opa_q : addr_a;
        state_d  = S_CAPA;
      end
      S_CAPA: begin
        opa_d = mem_rdata;
        if (ind_a && !deref_q) begin
          deref_d = 1'b1;
          state_d = S_RDA;
        end else begin
          deref_d = 1'b0;
          if (is_arith) begin
            state_d = S_RDB;
          end else if (is_dec) begin
            state_d = S_EXEC;
          end else begin
            pc_d    = br_take ? dst : pc_seq;
            state_d = S_IFETCH;
          end
        end
      end
      S_RDB: begin
        mem_addr = deref_q ? opb_q : addr_b;
        state_d  = S_CAPB;
      end
      S_CAPB: begin
        opb_d = mem_rdata;
        if (ind_b && !deref_q) begin
          deref_d = 1'b1;
          state_d = S_RDB;
        end else begin
          deref_d = 1'b0;
          state_d = S_EXEC;
        end
      end
      S_EXEC: begin
        mem_we   = 1'b1;
        mem_addr = is_dec ? src_a : dst;
        if (alu_div0) err_d = 1'b1;
        pc_d    = pc_seq;
        state_d = S_IFETCH;
      end
      S_HALT: state_d = S_HALT;
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IFETCH;
      pc_q    <= '0;
      idx_q   <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      deref_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      idx_q   <= idx_d;
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      deref_q <= deref_d;
      err_q   <= err_d;
    end
  end

  assign halted  = (state_q == S_HALT);
  assign div_err = err_q;
endmodule

// File: rtl/mm_cpu.sv
module mm_cpu
  import mm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic          div_err
);
  logic          rst_s1, rst_s2;
  alu_op_e       alu_op;
  logic [DW-1:0] alu_a, alu_b, alu_y;
  logic          alu_div0;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  mm_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s2),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .alu_op    (alu_op),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .alu_y     (alu_y),
    .alu_div0  (alu_div0),
    .halted    (halted),
    .div_err   (div_err)
  );

  mm_alu #(.DW(DW)) u_alu (
    .op   (alu_op),
    .a    (alu_a),
    .b    (alu_b),
    .y    (alu_y),
    .div0 (alu_div0)
  );
endmodule

// File: rtl/mm_cpu_chk.sv
module mm_cpu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted,
  input logic          div_err
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (mem_addr == '0 && !mem_we && !halted && !div_err); // R1
    end
  end

  AST_DIVERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err); // R5

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R9

  AST_HALT_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr)); // R9

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R10
endmodule

bind mm_cpu mm_cpu_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .halted   (halted),
  .div_err  (div_err)
);

// File: tb/sim_mm_cpu.sv
`timescale 1ns/1ps
module sim_mm_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, halted, div_err;
  logic [7:0] mem [256];
  int         n_chk = 0;
  int         n_fail = 0;
  int         wr_cnt = 0;

  always #2.5 clk = ~clk;

  mm_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .div_err(div_err)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (rst_n && mem_we) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic put(input int a, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] b3);
    mem[a] = b0; mem[a+1] = b1; mem[a+2] = b2; mem[a+3] = b3;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input string tag);
    int n;
    @(negedge clk);
    wr_cnt = 0;
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(halted == 1'b1, {tag, " halt reached"}, n, 3000);
  endtask

  task automatic t_reset();
    hold_reset();
    @(negedge clk);
    chk_eq("R1 mem_addr in reset", mem_addr, 0);
    chk_eq("R1 mem_we in reset", mem_we, 0);
    chk_eq("R1 halted in reset", halted, 0);
    chk_eq("R1 div_err in reset", div_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1 first fetch address", mem_addr, 0);
  endtask

  task automatic t_add();
    hold_reset();
    put(0, 8'h01, 8'h1C, 8'h3F, 8'h64);
    mem[28] = 8'd30; mem[63] = 8'd15;
    run("R2");
    chk_eq("R2 cell100 sum", mem[100], 45);
    chk_eq("R2 pc after one instr", mem_addr, 4);
    chk_eq("R10 writes for add", wr_cnt, 1);
  endtask

  task automatic t_arith();
    hold_reset();
    put(0, 8'h02, 8'h50, 8'h51, 8'h52);
    put(4, 8'h03, 8'h53, 8'h53, 8'hC8);
    put(8, 8'h04, 8'h54, 8'h55, 8'h56);
    mem[80] = 8'd5; mem[81] = 8'd9; mem[83] = 8'd20; mem[84] = 8'd200; mem[85] = 8'd7;
    run("R3");
    chk_eq("R3 sub wraps", mem[82], 252);
    chk_eq("R3 mul truncates to cell 200", mem[200], 144);
    chk_eq("R3 div", mem[86], 28);
    chk_eq("R3 div_err low", div_err, 0);
    chk_eq("R2 pc after three instr", mem_addr, 12);
  endtask

  task automatic t_div0();
    hold_reset();
    put(0, 8'h04, 8'h51, 8'h52, 8'h53);
    put(4, 8'h01, 8'h51, 8'h51, 8'h54);
    mem[81] = 8'd9; mem[82] = 8'd0;
    run("R5");
    chk_eq("R5 div0 result", mem[83], 255);
    chk_eq("R5 div_err sticky", div_err, 1);
    chk_eq("R5 later add still runs", mem[84], 18);
  endtask

  task automatic t_indirect();
    hold_reset();
    put(0, 8'h01, 8'hA8, 8'h29, 8'h32);
    put(4, 8'h01, 8'h2B, 8'hAA, 8'h33);
    mem[40] = 8'd100; mem[41] = 8'd3; mem[100] = 8'd77;
    mem[42] = 8'd120; mem[43] = 8'd2; mem[120] = 8'd11;
    run("R4");
    chk_eq("R4 indirect source A", mem[50], 80);
    chk_eq("R4 indirect source B", mem[51], 13);
  endtask

  task automatic t_loop();
    hold_reset();
    put(0,  8'h06, 8'h40, 8'h00, 8'h14);
    put(4,  8'h01, 8'h41, 8'hC2, 8'h41);
    put(8,  8'h05, 8'h42, 8'h00, 8'h00);
    put(12, 8'h05, 8'h40, 8'h00, 8'h00);
    put(16, 8'h08, 8'h00, 8'h00, 8'h00);
    mem[64] = 8'd3; mem[65] = 8'd0; mem[66] = 8'd70;
    mem[68] = 8'd10; mem[69] = 8'd20; mem[70] = 8'd30;
    run("R7");
    chk_eq("R7 loop sum", mem[65], 60);
    chk_eq("R6 counter decremented", mem[64], 0);
    chk_eq("R6 index decremented", mem[66], 67);
    chk_eq("R7 BZ taken exit pc", mem_addr, 20);
    chk_eq("R10 loop writes", wr_cnt, 9);
  endtask

  task automatic t_dec();
    hold_reset();
    put(0, 8'h05, 8'h5A, 8'h00, 8'h00);
    put(4, 8'h05, 8'h5B, 8'h00, 8'h00);
    mem[91] = 8'd10;
    run("R6");
    chk_eq("R6 dec wraps 0 to 255", mem[90], 255);
    chk_eq("R6 dec 10", mem[91], 9);
    chk_eq("R10 dec writes", wr_cnt, 2);
  endtask

  task automatic t_jump();
    hold_reset();
    put(0,  8'h08, 8'h00, 8'h00, 8'h10);
    put(4,  8'h01, 8'h60, 8'h60, 8'h5F);
    put(16, 8'h01, 8'h60, 8'h60, 8'h61);
    mem[95] = 8'h33; mem[96] = 8'd7;
    run("R8");
    chk_eq("R8 skipped instr no write", mem[95], 51);
    chk_eq("R8 target instr ran", mem[97], 14);
    chk_eq("R8 halt pc", mem_addr, 20);
    chk_eq("R10 jump writes", wr_cnt, 1);
  endtask

  task automatic t_bnz(input logic [7:0] tested);
    hold_reset();
    put(0,  8'h07, 8'h50, 8'h00, 8'h0C);
    put(4,  8'h01, 8'h51, 8'h51, 8'h52);
    put(12, 8'h01, 8'h51, 8'h51, 8'h53);
    mem[80] = tested; mem[81] = 8'd6;
    run("R7");
    if (tested == 8'd0) begin
      chk_eq("R7 BNZ not taken fallthrough", mem[82], 12);
      chk_eq("R7 BNZ not taken target skipped", mem[83], 0);
      chk_eq("R7 BNZ not taken halt pc", mem_addr, 8);
    end else begin
      chk_eq("R7 BNZ taken fallthrough skipped", mem[82], 0);
      chk_eq("R7 BNZ taken target ran", mem[83], 12);
      chk_eq("R7 BNZ taken halt pc", mem_addr, 16);
    end
    chk_eq("R10 branch makes no write", wr_cnt, 1);
  endtask

  task automatic t_undef();
    int w0;
    hold_reset();
    put(0, 8'h09, 8'h5A, 8'h5A, 8'h5A);
    put(4, 8'h01, 8'h5A, 8'h5A, 8'h5A);
    mem[90] = 8'd5;
    run("R9");
    w0 = wr_cnt;
    repeat (20) @(negedge clk);
    chk_eq("R9 halted holds", halted, 1);
    chk_eq("R9 no writes after halt", wr_cnt - w0, 0);
    chk_eq("R9 halt addr is offending instr", mem_addr, 0);
    chk_eq("R9 next instr not run", mem[90], 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_add();
    t_arith();
    t_div0();
    t_reset();
    t_indirect();
    t_loop();
    t_dec();
    t_jump();
    t_bnz(8'd0);
    t_bnz(8'd1);
    t_undef();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule